// File: doc/BRIEF.md
# Compact Halfword Instruction Decoder

This block turns one 16-bit compressed instruction into a normalized micro-operation for the downstream pipeline. The micro-operation has an operation class, three full 5-bit register numbers (destination, first source, second source), an immediate widened to `IMM_W` bits, and the instruction length in bytes. The caller supplies the following halfword as well. Only the jump-and-link form reads it, as the low 16 bits of its target.

The decoder covers several groups of compressed formats: immediate arithmetic and compare, constant shifts, short and compare-with-zero branches, scaled loads and stores (register-based, stack-based and PC-relative), the three-register add/subtract group, the register-register group, the register moves and jump-and-link. In the compressed formats, register fields are three bits wide and select one of eight registers through a fixed table. The immediates carry an implied scale that depends on the access size. A shift count field of zero stands for eight.

Some encodings are not decoded here: 64-bit-only operations, the extend prefix and the frame save/restore form. For these the decoder raises a reserved flag and emits an empty micro-operation. One cycle of latency is spent in a single output register stage.

Top module: `hw16_decoder`

## Requirements
- R1: While `rst_n` is low at a clock edge, the output register clears: `o_valid`=0, `o_rsvd`=0, `o_cls`=0 (the no-operation class, first in the package enumeration `uop_cls_e`), and all register numbers, `o_imm` and `o_len` are 0.
- R2: An instruction presented with `i_valid`=1 appears on the outputs after the next rising edge, with `o_valid`=1. When `i_valid`=0, `o_valid` drops to 0 after the edge and the micro-operation fields hold their previous values.
- R3: The major opcode sits in bits 15:11. The fields at bits 10:8 (rx), 7:5 (ry) and 4:2 (rz) select register numbers through the table 0→16, 1→17, 2→2, 3→3, 4→4, 5→5, 6→6, 7→7.
- R4: Opcode 6 is the shift group, with rd=rx and rs=ry. Bits 1:0 pick the class: 0 gives SLL, 2 gives SRL and 3 gives SRA. The immediate is bits 4:2, and 0 there means 8. Bits 1:0 = 1 is reserved.
- R5: Opcode 2 is BR, with the immediate equal to bits 10:0 shifted left 1 and sign-extended from 12 bits. Opcodes 4 and 5 are BEQZ and BNEZ on rs=rx, with the immediate equal to the signed low byte shifted left 1. Opcode 12 with bits 10:8 = 0 or 1 gives the same two classes with rs=24.
- R6: Register-based memory access uses base rs=rx, with rd (loads) or rt (stores) equal to ry. The 5-bit field in bits 4:0 is scaled by the access size: 1 for LB/LBU/SB (opcodes 16, 20, 24), 2 for LH/LHU/SH (17, 21, 25) and 4 for LW/SW (19, 27).
- R7: Stack word access uses rs=29 and an immediate equal to the unsigned low byte shifted left 2. Opcode 18 is LW with rd=rx, opcode 26 is SW with rt=rx, and opcode 12 with bits 10:8 = 2 is SW with rt=31. Opcode 22 is LWPC with rd=rx, rs=0 and the same immediate.
- R8: Opcode 3 gives length 4 and rd=31. Its class is JAL when bit 10 is 0 and JALX when bit 10 is 1. The immediate is {bits 4:0, bits 9:5, next halfword} shifted left 2, zero-extended.
- R9: Immediate arithmetic works as follows. Opcode 13 is ADDI with rd=rx, rs=0 and the unsigned low byte. Opcode 9 is ADDI with rd=rs=rx and the signed low byte. Opcode 0 is ADDI with rd=rx, rs=29 and the unsigned byte shifted left 2. Opcode 1 is ADDPC with rd=rx and the same immediate. Opcode 12 with bits 10:8 = 3 is ADDI with rd=rs=29 and the signed byte shifted left 3. Opcode 8 with bit 4 = 0 is ADDI with rd=ry, rs=rx and bits 3:0 sign-extended.
- R10: Opcodes 10, 11 and 14 write rd=24 from rs=rx using the unsigned low byte, as SLTI, SLTIU and XORI respectively.
- R11: Opcode 28 has rd=rz, rs=rx and rt=ry. Bits 1:0 = 1 gives ADD, 3 gives SUB, and 0 or 2 is reserved.
- R12: Opcode 29 decodes on bits 4:0. 0 is a jump: bit 6 makes it JALR with rd=31, and bit 5 takes rs=31 instead of rx. 2 and 3 are SLT and SLTU into rd=24. 4, 6 and 7 are the variable shifts with rd=rt=ry and rs=rx. 5 is BRK with imm=bits 10:5. 10 is XOR into rd=24. 11 is SUB with rd=rx, rs=0 and rt=ry. 12, 13 and 14 are AND, OR and XOR into rd=rs=rx. 15 is NOR with rd=rx and rs=ry. 16 and 18 are MFHI and MFLO into rd=rx. 17 is an extend-in-place on rd=rs=rx selected by bits 7:5 (0 ZEB, 1 ZEH, 4 SEB, 5 SEH). 24 to 27 are MULT, MULTU, DIV and DIVU on rs=rx, rt=ry. All other values are reserved.
- R13: Opcode 12 with bits 10:8 = 5 is MOVE with rd={bits 4:3, bits 7:5} and rs=table(bits 2:0). With bits 10:8 = 7 it is MOVE with rd=ry and rs=bits 4:0.
- R14: Reserved encodings raise `o_rsvd` with class 0 and zero register numbers and immediate. These are opcodes 7, 15, 23, 30 and 31, opcode 8 with bit 4 set, opcode 12 with bits 10:8 = 4 or 6, and the reserved sub-codes of R4, R11 and R12. `o_len` is 4 for opcode 30 and 2 for every other reserved encoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| i_valid | input | 1 | Instruction present this cycle |
| i_insn | input | 16 | Compressed instruction halfword |
| i_next | input | 16 | Following halfword (jump target low part) |
| o_valid | output | 1 | Micro-operation valid |
| o_cls | output | 6 | Operation class, `uop_cls_e` encoding |
| o_rd | output | 5 | Destination register number |
| o_rs | output | 5 | First source / base register number |
| o_rt | output | 5 | Second source / store data register number |
| o_imm | output | IMM_W | Extended and scaled immediate |
| o_len | output | 3 | Instruction length in bytes |
| o_rsvd | output | 1 | Reserved or unsupported encoding |

## Verification
The bench builds the decoder with the default `IMM_W` of 32. At that width the full 28-bit jump target is visible, including its bit 27. The sign extension of every negative immediate kind can also be checked across all upper bits. The width puts the sign-extension boundaries within reach: the 12-bit branch offset at its extremes, the 0x80 byte, and the 4-bit immediate at its minimum. The shift field value that means eight and the largest scaled offsets are covered as well.

// File: rtl/hw16_pkg.sv
// Shared constants and types for the compact halfword decoder.
// Assumes the compressed format is fixed at 16 bits with 5-bit register numbers.
package hw16_pkg;

    localparam int HALF_W = 16;
    localparam int RNUM_W = 5;
    localparam int OPC_W  = 5;
    localparam int CLS_W  = 6;
    localparam int LEN_W  = 3;
    localparam int FLD_W  = 3;

    localparam logic [RNUM_W-1:0] REG_ZERO = 5'd0;
    localparam logic [RNUM_W-1:0] REG_T    = 5'd24;
    localparam logic [RNUM_W-1:0] REG_SP   = 5'd29;
    localparam logic [RNUM_W-1:0] REG_RA   = 5'd31;

    // Micro-operation classes; the no-operation class must stay first (code 0).
    typedef enum logic [CLS_W-1:0] {
        UOP_NOP, UOP_ADDI, UOP_ADDPC, UOP_SLTI, UOP_SLTIU, UOP_XORI,
        UOP_SLL, UOP_SRL, UOP_SRA, UOP_SLLV, UOP_SRLV, UOP_SRAV,
        UOP_ADD, UOP_SUB, UOP_SLT, UOP_SLTU, UOP_AND, UOP_OR, UOP_XOR, UOP_NOR,
        UOP_MOVE, UOP_MFHI, UOP_MFLO, UOP_MULT, UOP_MULTU, UOP_DIV, UOP_DIVU,
        UOP_ZEB, UOP_ZEH, UOP_SEB, UOP_SEH,
        UOP_BR, UOP_BEQZ, UOP_BNEZ, UOP_JAL, UOP_JALX, UOP_JR, UOP_JALR,
        UOP_LB, UOP_LBU, UOP_LH, UOP_LHU, UOP_LW, UOP_LWPC,
        UOP_SB, UOP_SH, UOP_SW, UOP_BRK
    } uop_cls_e;

    // Immediate construction recipes chosen by the field decoder.
    typedef enum logic [3:0] {
        IK_ZERO, IK_U8S2, IK_B11, IK_S8S1, IK_S8, IK_U8, IK_S4, IK_S8S3,
        IK_SA, IK_O5, IK_O5S1, IK_O5S2, IK_JT, IK_CODE6
    } imm_kind_e;

endpackage

// File: rtl/hw16_regmap.sv
// Expands a 3-bit compressed register field to a full register number.
// Assumes the fixed eight-entry table of the compressed format.
module hw16_regmap
    import hw16_pkg::*;
(
    input  logic [FLD_W-1:0]  i_field,
    output logic [RNUM_W-1:0] o_reg
);

    // Table lookup: fields 0 and 1 reach the saved registers, the rest map to themselves.
    always_comb begin
        unique case (i_field)
            3'd0:    o_reg = 5'd16;
            3'd1:    o_reg = 5'd17;
            default: o_reg = {2'b00, i_field};
        endcase
    end

endmodule

// File: rtl/hw16_immgen.sv
// Builds the extended, scaled immediate from the instruction and a recipe.
// Assumes IMM_W is at least 28 so the jump target fits unshortened.
module hw16_immgen
    import hw16_pkg::*;
#(
    parameter int IMM_W = 32
) (
    input  logic [HALF_W-1:0] i_insn,
    input  logic [HALF_W-1:0] i_next,
    input  imm_kind_e         i_kind,
    output logic [IMM_W-1:0]  o_imm
);

    localparam int JT_W = 2 * OPC_W + HALF_W + 2;

    logic       sa_zero;
    logic [7:0] lo8;
    logic [4:0] lo5;

    assign lo8     = i_insn[7:0];
    assign lo5     = i_insn[4:0];
    assign sa_zero = (i_insn[4:2] == 3'd0);

    // Select and extend the immediate according to the recipe.
    always_comb begin
        unique case (i_kind)
            IK_U8S2:  o_imm = {{(IMM_W-10){1'b0}}, lo8, 2'b00};
            IK_B11:   o_imm = {{(IMM_W-12){i_insn[10]}}, i_insn[10:0], 1'b0};
            IK_S8S1:  o_imm = {{(IMM_W-9){lo8[7]}}, lo8, 1'b0};
            IK_S8:    o_imm = {{(IMM_W-8){lo8[7]}}, lo8};
            IK_U8:    o_imm = {{(IMM_W-8){1'b0}}, lo8};
            IK_S4:    o_imm = {{(IMM_W-4){i_insn[3]}}, i_insn[3:0]};
            IK_S8S3:  o_imm = {{(IMM_W-11){lo8[7]}}, lo8, 3'b000};
            IK_SA:    o_imm = {{(IMM_W-4){1'b0}}, sa_zero, i_insn[4:2]};
            IK_O5:    o_imm = {{(IMM_W-5){1'b0}}, lo5};
            IK_O5S1:  o_imm = {{(IMM_W-6){1'b0}}, lo5, 1'b0};
            IK_O5S2:  o_imm = {{(IMM_W-7){1'b0}}, lo5, 2'b00};
            IK_JT:    o_imm = {{(IMM_W-JT_W){1'b0}}, i_insn[4:0], i_insn[9:5], i_next, 2'b00};
            IK_CODE6: o_imm = {{(IMM_W-6){1'b0}}, i_insn[10:5]};
            default:  o_imm = '0;
        endcase
    end

endmodule

// File: rtl/hw16_core.sv
// Field decoder: opcode and sub-function to class, register numbers, immediate
// recipe, length and reserved flag. Assumes mapped register fields come in
// already expanded (rx, ry, rz and the low-field source).
module hw16_core
    import hw16_pkg::*;
(
    input  logic [HALF_W-1:0] i_insn,
    input  logic [RNUM_W-1:0] i_rx,
    input  logic [RNUM_W-1:0] i_ry,
    input  logic [RNUM_W-1:0] i_rz,
    input  logic [RNUM_W-1:0] i_rw,
    output uop_cls_e          o_cls,
    output logic [RNUM_W-1:0] o_rd,
    output logic [RNUM_W-1:0] o_rs,
    output logic [RNUM_W-1:0] o_rt,
    output imm_kind_e         o_kind,
    output logic [LEN_W-1:0]  o_len,
    output logic              o_rsvd
);

    logic [OPC_W-1:0] opc;
    uop_cls_e          cls;
    logic [RNUM_W-1:0] rd, rs, rt;
    imm_kind_e         kind;
    logic              rsvd;

    assign opc = i_insn[15:11];

    // Main opcode decode producing a raw micro-operation and reserved indication.
    always_comb begin
        cls   = UOP_NOP;
        rd    = REG_ZERO;
        rs    = REG_ZERO;
        rt    = REG_ZERO;
        kind  = IK_ZERO;
        o_len = LEN_W'(2);
        rsvd  = 1'b0;
        unique case (opc)
            5'h00: begin cls = UOP_ADDI;  rd = i_rx; rs = REG_SP; kind = IK_U8S2; end
            5'h01: begin cls = UOP_ADDPC; rd = i_rx; kind = IK_U8S2; end
            5'h02: begin cls = UOP_BR;    kind = IK_B11; end
            5'h03: begin
                cls   = i_insn[10] ? UOP_JALX : UOP_JAL;
                rd    = REG_RA;
                kind  = IK_JT;
                o_len = LEN_W'(4);
            end
            5'h04: begin cls = UOP_BEQZ; rs = i_rx; kind = IK_S8S1; end
            5'h05: begin cls = UOP_BNEZ; rs = i_rx; kind = IK_S8S1; end
            5'h06: begin
                rd   = i_rx;
                rs   = i_ry;
                kind = IK_SA;
                unique case (i_insn[1:0])
                    2'd0:    cls  = UOP_SLL;
                    2'd2:    cls  = UOP_SRL;
                    2'd3:    cls  = UOP_SRA;
                    default: rsvd = 1'b1;
                endcase
            end
            5'h08: begin
                if (i_insn[4]) begin
                    rsvd = 1'b1;
                end else begin
                    cls = UOP_ADDI; rd = i_ry; rs = i_rx; kind = IK_S4;
                end
            end
            5'h09: begin cls = UOP_ADDI;  rd = i_rx;  rs = i_rx; kind = IK_S8; end
            5'h0a: begin cls = UOP_SLTI;  rd = REG_T; rs = i_rx; kind = IK_U8; end
            5'h0b: begin cls = UOP_SLTIU; rd = REG_T; rs = i_rx; kind = IK_U8; end
            5'h0c: begin
                unique case (i_insn[10:8])
                    3'd0: begin cls = UOP_BEQZ; rs = REG_T; kind = IK_S8S1; end
                    3'd1: begin cls = UOP_BNEZ; rs = REG_T; kind = IK_S8S1; end
                    3'd2: begin cls = UOP_SW;   rs = REG_SP; rt = REG_RA; kind = IK_U8S2; end
                    3'd3: begin cls = UOP_ADDI; rd = REG_SP; rs = REG_SP; kind = IK_S8S3; end
                    3'd5: begin cls = UOP_MOVE; rd = {i_insn[4:3], i_insn[7:5]}; rs = i_rw; end
                    3'd7: begin cls = UOP_MOVE; rd = i_ry; rs = i_insn[4:0]; end
                    default: rsvd = 1'b1;
                endcase
            end
            5'h0d: begin cls = UOP_ADDI; rd = i_rx;  rs = REG_ZERO; kind = IK_U8; end
            5'h0e: begin cls = UOP_XORI; rd = REG_T; rs = i_rx;     kind = IK_U8; end
            5'h10: begin cls = UOP_LB;   rd = i_ry; rs = i_rx;   kind = IK_O5;   end
            5'h11: begin cls = UOP_LH;   rd = i_ry; rs = i_rx;   kind = IK_O5S1; end
            5'h12: begin cls = UOP_LW;   rd = i_rx; rs = REG_SP; kind = IK_U8S2; end
            5'h13: begin cls = UOP_LW;   rd = i_ry; rs = i_rx;   kind = IK_O5S2; end
            5'h14: begin cls = UOP_LBU;  rd = i_ry; rs = i_rx;   kind = IK_O5;   end
            5'h15: begin cls = UOP_LHU;  rd = i_ry; rs = i_rx;   kind = IK_O5S1; end
            5'h16: begin cls = UOP_LWPC; rd = i_rx; kind = IK_U8S2; end
            5'h18: begin cls = UOP_SB;   rt = i_ry; rs = i_rx;   kind = IK_O5;   end
            5'h19: begin cls = UOP_SH;   rt = i_ry; rs = i_rx;   kind = IK_O5S1; end
            5'h1a: begin cls = UOP_SW;   rt = i_rx; rs = REG_SP; kind = IK_U8S2; end
            5'h1b: begin cls = UOP_SW;   rt = i_ry; rs = i_rx;   kind = IK_O5S2; end
            5'h1c: begin
                rd = i_rz;
                rs = i_rx;
                rt = i_ry;
                unique case (i_insn[1:0])
                    2'd1:    cls  = UOP_ADD;
                    2'd3:    cls  = UOP_SUB;
                    default: rsvd = 1'b1;
                endcase
            end
            5'h1d: begin
                unique case (i_insn[4:0])
                    5'h00: begin
                        cls = i_insn[6] ? UOP_JALR : UOP_JR;
                        rd  = i_insn[6] ? REG_RA : REG_ZERO;
                        rs  = i_insn[5] ? REG_RA : i_rx;
                    end
                    5'h02: begin cls = UOP_SLT;  rd = REG_T; rs = i_rx; rt = i_ry; end
                    5'h03: begin cls = UOP_SLTU; rd = REG_T; rs = i_rx; rt = i_ry; end
                    5'h04: begin cls = UOP_SLLV; rd = i_ry;  rs = i_rx; rt = i_ry; end
                    5'h05: begin cls = UOP_BRK;  kind = IK_CODE6; end
                    5'h06: begin cls = UOP_SRLV; rd = i_ry;  rs = i_rx; rt = i_ry; end
                    5'h07: begin cls = UOP_SRAV; rd = i_ry;  rs = i_rx; rt = i_ry; end
                    5'h0a: begin cls = UOP_XOR;  rd = REG_T; rs = i_rx; rt = i_ry; end
                    5'h0b: begin cls = UOP_SUB;  rd = i_rx;  rs = REG_ZERO; rt = i_ry; end
                    5'h0c: begin cls = UOP_AND;  rd = i_rx;  rs = i_rx; rt = i_ry; end
                    5'h0d: begin cls = UOP_OR;   rd = i_rx;  rs = i_rx; rt = i_ry; end
                    5'h0e: begin cls = UOP_XOR;  rd = i_rx;  rs = i_rx; rt = i_ry; end
                    5'h0f: begin cls = UOP_NOR;  rd = i_rx;  rs = i_ry; end
                    5'h10: begin cls = UOP_MFHI; rd = i_rx; end
                    5'h12: begin cls = UOP_MFLO; rd = i_rx; end
                    5'h11: begin
                        rd = i_rx;
                        rs = i_rx;
                        unique case (i_insn[7:5])
                            3'd0:    cls  = UOP_ZEB;
                            3'd1:    cls  = UOP_ZEH;
                            3'd4:    cls  = UOP_SEB;
                            3'd5:    cls  = UOP_SEH;
                            default: rsvd = 1'b1;
                        endcase
                    end
                    5'h18: begin cls = UOP_MULT;  rs = i_rx; rt = i_ry; end
                    5'h19: begin cls = UOP_MULTU; rs = i_rx; rt = i_ry; end
                    5'h1a: begin cls = UOP_DIV;   rs = i_rx; rt = i_ry; end
                    5'h1b: begin cls = UOP_DIVU;  rs = i_rx; rt = i_ry; end
                    default: rsvd = 1'b1;
                endcase
            end
            5'h1e: begin rsvd = 1'b1; o_len = LEN_W'(4); end
            default: rsvd = 1'b1;
        endcase
    end

    // Squash every field of a reserved encoding to an empty micro-operation.
    always_comb begin
        o_rsvd = rsvd;
        o_cls  = rsvd ? UOP_NOP  : cls;
        o_rd   = rsvd ? REG_ZERO : rd;
        o_rs   = rsvd ? REG_ZERO : rs;
        o_rt   = rsvd ? REG_ZERO : rt;
        o_kind = rsvd ? IK_ZERO  : kind;
    end

endmodule

// File: rtl/hw16_decoder.sv
// Top of the compact halfword decoder: field expansion, decode, immediate
// build and one output register stage. Assumes IMM_W >= 28; reset is
// synchronous and active low.
module hw16_decoder
    import hw16_pkg::*;
#(
    parameter int IMM_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              i_valid,
    input  logic [15:0]       i_insn,
    input  logic [15:0]       i_next,
    output logic              o_valid,
    output logic [5:0]        o_cls,
    output logic [4:0]        o_rd,
    output logic [4:0]        o_rs,
    output logic [4:0]        o_rt,
    output logic [IMM_W-1:0]  o_imm,
    output logic [2:0]        o_len,
    output logic              o_rsvd
);

    localparam int NUM_FIELDS = 4;

    logic [RNUM_W-1:0] rmap [NUM_FIELDS];

    uop_cls_e          d_cls;
    logic [RNUM_W-1:0] d_rd, d_rs, d_rt;
    imm_kind_e         d_kind;
    logic [LEN_W-1:0]  d_len;
    logic              d_rsvd;
    logic [IMM_W-1:0]  d_imm;

    // One table lookup per 3-bit field: rx, ry, rz and the low source field.
    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
        localparam int LSB = (g == 0) ? 8 : (g == 1) ? 5 : (g == 2) ? 2 : 0;
        hw16_regmap u_map (
            .i_field (i_insn[LSB +: FLD_W]),
            .o_reg   (rmap[g])
        );
    end

    hw16_core u_core (
        .i_insn (i_insn),
        .i_rx   (rmap[0]),
        .i_ry   (rmap[1]),
        .i_rz   (rmap[2]),
        .i_rw   (rmap[3]),
        .o_cls  (d_cls),
        .o_rd   (d_rd),
        .o_rs   (d_rs),
        .o_rt   (d_rt),
        .o_kind (d_kind),
        .o_len  (d_len),
        .o_rsvd (d_rsvd)
    );

    hw16_immgen #(.IMM_W(IMM_W)) u_imm (
        .i_insn (i_insn),
        .i_next (i_next),
        .i_kind (d_kind),
        .o_imm  (d_imm)
    );

    // Output stage: clear on reset, capture on valid, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_valid <= 1'b0;
            o_cls   <= '0;
            o_rd    <= '0;
            o_rs    <= '0;
            o_rt    <= '0;
            o_imm   <= '0;
            o_len   <= '0;
            o_rsvd  <= 1'b0;
        end else begin
            o_valid <= i_valid;
            if (i_valid) begin
                o_cls  <= d_cls;
                o_rd   <= d_rd;
                o_rs   <= d_rs;
                o_rt   <= d_rt;
                o_imm  <= d_imm;
                o_len  <= d_len;
                o_rsvd <= d_rsvd;
            end
        end
    end

endmodule

// File: rtl/hw16_decoder_chk.sv
// Property checker for the compact halfword decoder, bound to the top module.
// Assumes only port-level visibility of the decoder.
module hw16_decoder_chk
    import hw16_pkg::*;
#(
    parameter int IMM_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             i_valid,
    input logic [15:0]      i_insn,
    input logic             o_valid,
    input logic [5:0]       o_cls,
    input logic [4:0]       o_rd,
    input logic [4:0]       o_rs,
    input logic [4:0]       o_rt,
    input logic [IMM_W-1:0] o_imm,
    input logic [2:0]       o_len,
    input logic             o_rsvd
);

    logic is_shift, is_word;
    assign is_shift = (o_cls == UOP_SLL) || (o_cls == UOP_SRL) || (o_cls == UOP_SRA);
    assign is_word  = (o_cls == UOP_LW) || (o_cls == UOP_SW) || (o_cls == UOP_LWPC);

    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        i_valid |=> o_valid);

    assert_idle_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !i_valid |=> (!o_valid && $stable(o_cls) && $stable(o_imm)));

    assert_shift_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (o_valid && is_shift) |-> (o_imm >= IMM_W'(1) && o_imm <= IMM_W'(8)));

    assert_word_align_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (o_valid && is_word) |-> (o_imm[1:0] == 2'b00));

    assert_jal_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (i_valid && i_insn[15:11] == 5'h03) |=> (o_len == 3'd4 && !o_rsvd && o_rd == 5'd31));

    assert_reserved_empty_R14: assert property (@(posedge clk) disable iff (!rst_n)
        o_rsvd |-> (o_cls == 6'd0 && o_rd == 5'd0 && o_rs == 5'd0 && o_rt == 5'd0 && o_imm == '0));

    assert_wide_op_rsvd_R14: assert property (@(posedge clk) disable iff (!rst_n)
        (i_valid && i_insn[15:11] inside {5'h07, 5'h0f, 5'h17, 5'h1f}) |=> (o_rsvd && o_len == 3'd2));

endmodule

bind hw16_decoder hw16_decoder_chk #(.IMM_W(IMM_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .i_valid (i_valid),
    .i_insn  (i_insn),
    .o_valid (o_valid),
    .o_cls   (o_cls),
    .o_rd    (o_rd),
    .o_rs    (o_rs),
    .o_rt    (o_rt),
    .o_imm   (o_imm),
    .o_len   (o_len),
    .o_rsvd  (o_rsvd)
);

// File: tb/hw16_decoder_tb.sv
`timescale 1ns/100ps
// Directed bench for the compact halfword decoder; one task per scenario.
module hw16_decoder_tb;
    import hw16_pkg::*;

    localparam int IMM_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              i_valid = 1'b0;
    logic [15:0]       i_insn = '0;
    logic [15:0]       i_next = '0;
    logic              o_valid;
    logic [5:0]        o_cls;
    logic [4:0]        o_rd, o_rs, o_rt;
    logic [IMM_W-1:0]  o_imm;
    logic [2:0]        o_len;
    logic              o_rsvd;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    hw16_decoder #(.IMM_W(IMM_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .i_valid(i_valid), .i_insn(i_insn), .i_next(i_next),
        .o_valid(o_valid), .o_cls(o_cls), .o_rd(o_rd), .o_rs(o_rs), .o_rt(o_rt),
        .o_imm(o_imm), .o_len(o_len), .o_rsvd(o_rsvd)
    );

    // Register table written from the requirement.
    function automatic logic [4:0] tbl(input logic [2:0] f);
        case (f)
            3'd0:    return 5'd16;
            3'd1:    return 5'd17;
            default: return {2'b00, f};
        endcase
    endfunction

    // Present one instruction, wait for the output stage, compare every field.
    task automatic chk(input string req, input logic [15:0] insn, input logic [15:0] nxt,
                       input uop_cls_e cls, input logic [4:0] rd, input logic [4:0] rs,
                       input logic [4:0] rt, input logic [31:0] imm, input int len,
                       input bit rsvd);
        @(negedge clk);
        i_valid = 1'b1;
        i_insn  = insn;
        i_next  = nxt;
        @(posedge clk);
        #1;
        i_valid = 1'b0;
        checks++;
        if (o_valid !== 1'b1 || o_cls !== 6'(cls) || o_rd !== rd || o_rs !== rs ||
            o_rt !== rt || o_imm !== imm || o_len !== 3'(len) || o_rsvd !== rsvd) begin
            fails++;
            $display("FAIL %s insn=%h: act v=%0b cls=%0d rd=%0d rs=%0d rt=%0d imm=%h len=%0d rsvd=%0b exp v=1 cls=%0d rd=%0d rs=%0d rt=%0d imm=%h len=%0d rsvd=%0b",
                     req, insn, o_valid, o_cls, o_rd, o_rs, o_rt, o_imm, o_len, o_rsvd,
                     6'(cls), rd, rs, rt, imm, len, rsvd);
        end
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        checks++;
        if (o_valid !== 1'b0 || o_cls !== 6'd0 || o_rd !== 5'd0 || o_rs !== 5'd0 ||
            o_rt !== 5'd0 || o_imm !== '0 || o_len !== 3'd0 || o_rsvd !== 1'b0) begin
            fails++;
            $display("FAIL R1 reset: act v=%0b cls=%0d imm=%h len=%0d rsvd=%0b exp all zero",
                     o_valid, o_cls, o_imm, o_len, o_rsvd);
        end
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // R3: every table entry through the rx field of the signed add form.
    task automatic t_regmap;
        for (int f = 0; f < 8; f++) begin
            chk("R3", {5'h09, 3'(f), 8'h01}, 16'h0, UOP_ADDI, tbl(3'(f)), tbl(3'(f)), 5'd0,
                32'h1, 2, 1'b0);
        end
        chk("R3", {5'h10, 3'd7, 3'd0, 5'd0}, 16'h0, UOP_LB, 5'd16, 5'd7, 5'd0, 32'h0, 2, 1'b0);
    endtask

    task automatic t_shifts;
        chk("R4", {5'h06, 3'd0, 3'd1, 3'd0, 2'd0}, 16'h0, UOP_SLL, 5'd16, 5'd17, 5'd0, 32'd8, 2, 1'b0);
        chk("R4", {5'h06, 3'd2, 3'd7, 3'd3, 2'd3}, 16'h0, UOP_SRA, 5'd2, 5'd7, 5'd0, 32'd3, 2, 1'b0);
        chk("R4", {5'h06, 3'd4, 3'd5, 3'd7, 2'd2}, 16'h0, UOP_SRL, 5'd4, 5'd5, 5'd0, 32'd7, 2, 1'b0);
        chk("R4", {5'h06, 3'd4, 3'd5, 3'd1, 2'd1}, 16'h0, UOP_NOP, 5'd0, 5'd0, 5'd0, 32'd0, 2, 1'b1);
    endtask

    task automatic t_branches;
        chk("R5", {5'h02, 11'h7FF}, 16'h0, UOP_BR, 5'd0, 5'd0, 5'd0, 32'hFFFF_FFFE, 2, 1'b0);
        chk("R5", {5'h02, 11'h3FF}, 16'h0, UOP_BR, 5'd0, 5'd0, 5'd0, 32'h0000_07FE, 2, 1'b0);
        chk("R5", {5'h04, 3'd3, 8'h80}, 16'h0, UOP_BEQZ, 5'd0, 5'd3, 5'd0, 32'hFFFF_FF00, 2, 1'b0);
        chk("R5", {5'h05, 3'd1, 8'h7F}, 16'h0, UOP_BNEZ, 5'd0, 5'd17, 5'd0, 32'h0000_00FE, 2, 1'b0);
        chk("R5", {5'h0c, 3'd1, 8'h05}, 16'h0, UOP_BNEZ, 5'd0, 5'd24, 5'd0, 32'd10, 2, 1'b0);
        chk("R5", {5'h0c, 3'd0, 8'hFF}, 16'h0, UOP_BEQZ, 5'd0, 5'd24, 5'd0, 32'hFFFF_FFFE, 2, 1'b0);
    endtask

    task automatic t_mem;
        chk("R6", {5'h13, 3'd4, 3'd5, 5'd31}, 16'h0, UOP_LW,  5'd5,  5'd4,  5'd0, 32'd124, 2, 1'b0);
        chk("R6", {5'h11, 3'd0, 3'd1, 5'd3},  16'h0, UOP_LH,  5'd17, 5'd16, 5'd0, 32'd6,   2, 1'b0);
        chk("R6", {5'h10, 3'd2, 3'd3, 5'd31}, 16'h0, UOP_LB,  5'd3,  5'd2,  5'd0, 32'd31,  2, 1'b0);
        chk("R6", {5'h14, 3'd2, 3'd3, 5'd9},  16'h0, UOP_LBU, 5'd3,  5'd2,  5'd0, 32'd9,   2, 1'b0);
        chk("R6", {5'h15, 3'd6, 3'd7, 5'd31}, 16'h0, UOP_LHU, 5'd7,  5'd6,  5'd0, 32'd62,  2, 1'b0);
        chk("R6", {5'h18, 3'd2, 3'd3, 5'd7},  16'h0, UOP_SB,  5'd0,  5'd2,  5'd3, 32'd7,   2, 1'b0);
        chk("R6", {5'h19, 3'd5, 3'd4, 5'd2},  16'h0, UOP_SH,  5'd0,  5'd5,  5'd4, 32'd4,   2, 1'b0);
        chk("R6", {5'h1b, 3'd1, 3'd0, 5'd1},  16'h0, UOP_SW,  5'd0,  5'd17, 5'd16, 32'd4,  2, 1'b0);
    endtask

    task automatic t_sp_pc;
        chk("R7", {5'h12, 3'd6, 8'hFF}, 16'h0, UOP_LW,   5'd6,  5'd29, 5'd0,  32'd1020, 2, 1'b0);
        chk("R7", {5'h16, 3'd1, 8'h10}, 16'h0, UOP_LWPC, 5'd17, 5'd0,  5'd0,  32'd64,   2, 1'b0);
        chk("R7", {5'h1a, 3'd7, 8'h01}, 16'h0, UOP_SW,   5'd0,  5'd29, 5'd7,  32'd4,    2, 1'b0);
        chk("R7", {5'h0c, 3'd2, 8'h03}, 16'h0, UOP_SW,   5'd0,  5'd29, 5'd31, 32'd12,   2, 1'b0);
    endtask

    task automatic t_jal;
        chk("R8", {5'h03, 1'b0, 5'h1F, 5'h01}, 16'h1234, UOP_JAL,  5'd31, 5'd0, 5'd0, 32'h00FC_48D0, 4, 1'b0);
        chk("R8", {5'h03, 1'b1, 5'h00, 5'h10}, 16'hFFFF, UOP_JALX, 5'd31, 5'd0, 5'd0, 32'h0803_FFFC, 4, 1'b0);
    endtask

    task automatic t_imm_alu;
        chk("R9", {5'h0d, 3'd2, 8'hF0}, 16'h0, UOP_ADDI,  5'd2,  5'd0,  5'd0, 32'h0000_00F0, 2, 1'b0);
        chk("R9", {5'h09, 3'd0, 8'hF0}, 16'h0, UOP_ADDI,  5'd16, 5'd16, 5'd0, 32'hFFFF_FFF0, 2, 1'b0);
        chk("R9", {5'h0c, 3'd3, 8'hFF}, 16'h0, UOP_ADDI,  5'd29, 5'd29, 5'd0, 32'hFFFF_FFF8, 2, 1'b0);
        chk("R9", {5'h08, 3'd1, 3'd2, 1'b0, 4'h8}, 16'h0, UOP_ADDI, 5'd2, 5'd17, 5'd0, 32'hFFFF_FFF8, 2, 1'b0);
        chk("R9", {5'h00, 3'd4, 8'h02}, 16'h0, UOP_ADDI,  5'd4,  5'd29, 5'd0, 32'd8, 2, 1'b0);
        chk("R9", {5'h01, 3'd5, 8'h80}, 16'h0, UOP_ADDPC, 5'd5,  5'd0,  5'd0, 32'd512, 2, 1'b0);
        chk("R10", {5'h0e, 3'd5, 8'h81}, 16'h0, UOP_XORI,  5'd24, 5'd5,  5'd0, 32'h81, 2, 1'b0);
        chk("R10", {5'h0b, 3'd1, 8'h80}, 16'h0, UOP_SLTIU, 5'd24, 5'd17, 5'd0, 32'h80, 2, 1'b0);
        chk("R10", {5'h0a, 3'd3, 8'hFF}, 16'h0, UOP_SLTI,  5'd24, 5'd3,  5'd0, 32'hFF, 2, 1'b0);
    endtask

    task automatic t_rrr;
        chk("R11", {5'h1c, 3'd1, 3'd2, 3'd0, 2'd3}, 16'h0, UOP_SUB, 5'd16, 5'd17, 5'd2, 32'd0, 2, 1'b0);
        chk("R11", {5'h1c, 3'd6, 3'd7, 3'd5, 2'd1}, 16'h0, UOP_ADD, 5'd5, 5'd6, 5'd7, 32'd0, 2, 1'b0);
        chk("R11", {5'h1c, 3'd6, 3'd7, 3'd5, 2'd0}, 16'h0, UOP_NOP, 5'd0, 5'd0, 5'd0, 32'd0, 2, 1'b1);
    endtask

    task automatic t_rr;
        chk("R12", {5'h1d, 3'd4, 3'd5, 5'h0c}, 16'h0, UOP_AND,  5'd4,  5'd4,  5'd5, 32'd0, 2, 1'b0);
        chk("R12", {5'h1d, 3'd6, 3'd7, 5'h0b}, 16'h0, UOP_SUB,  5'd6,  5'd0,  5'd7, 32'd0, 2, 1'b0);
        chk("R12", {5'h1d, 3'd0, 3'b001, 5'h00}, 16'h0, UOP_JR, 5'd0,  5'd31, 5'd0, 32'd0, 2, 1'b0);
        chk("R12", {5'h1d, 3'd2, 3'b010, 5'h00}, 16'h0, UOP_JALR, 5'd31, 5'd2, 5'd0, 32'd0, 2, 1'b0);
        chk("R12", {5'h1d, 3'd3, 3'd5, 5'h11}, 16'h0, UOP_SEH,  5'd3,  5'd3,  5'd0, 32'd0, 2, 1'b0);
        chk("R12", {5'h1d, 3'd3, 3'd2, 5'h11}, 16'h0, UOP_NOP,  5'd0,  5'd0,  5'd0, 32'd0, 2, 1'b1);
        chk("R12", {5'h1d, 3'd1, 3'd3, 5'h02}, 16'h0, UOP_SLT,  5'd24, 5'd17, 5'd3, 32'd0, 2, 1'b0);
        chk("R12", {5'h1d, 3'd4, 3'd6, 5'h07}, 16'h0, UOP_SRAV, 5'd6,  5'd4,  5'd6, 32'd0, 2, 1'b0);
        chk("R12", {5'h1d, 3'd5, 3'd0, 5'h0f}, 16'h0, UOP_NOR,  5'd5,  5'd16, 5'd0, 32'd0, 2, 1'b0);
        chk("R12", {5'h1d, 3'd2, 3'd0, 5'h12}, 16'h0, UOP_MFLO, 5'd2,  5'd0,  5'd0, 32'd0, 2, 1'b0);
        chk("R12", {5'h1d, 3'd7, 3'd1, 5'h1b}, 16'h0, UOP_DIVU, 5'd0,  5'd7,  5'd17, 32'd0, 2, 1'b0);
        chk("R12", {5'h1d, 6'h2A, 5'h05},      16'h0, UOP_BRK,  5'd0,  5'd0,  5'd0, 32'h2A, 2, 1'b0);
        chk("R12", {5'h1d, 3'd1, 3'd1, 5'h08}, 16'h0, UOP_NOP,  5'd0,  5'd0,  5'd0, 32'd0, 2, 1'b1);
    endtask

    task automatic t_moves;
        chk("R13", {5'h0c, 3'd5, 3'b101, 2'b11, 3'd0}, 16'h0, UOP_MOVE, 5'd29, 5'd16, 5'd0, 32'd0, 2, 1'b0);
        chk("R13", {5'h0c, 3'd7, 3'd2, 5'd31},         16'h0, UOP_MOVE, 5'd2,  5'd31, 5'd0, 32'd0, 2, 1'b0);
    endtask

    task automatic t_reserved;
        chk("R14", {5'h07, 11'h7FF}, 16'h0, UOP_NOP, 5'd0, 5'd0, 5'd0, 32'd0, 2, 1'b1);
        chk("R14", {5'h1e, 11'h123}, 16'h0, UOP_NOP, 5'd0, 5'd0, 5'd0, 32'd0, 4, 1'b1);
        chk("R14", {5'h1f, 11'h000}, 16'h0, UOP_NOP, 5'd0, 5'd0, 5'd0, 32'd0, 2, 1'b1);
        chk("R14", {5'h08, 3'd1, 3'd2, 1'b1, 4'h3}, 16'h0, UOP_NOP, 5'd0, 5'd0, 5'd0, 32'd0, 2, 1'b1);
        chk("R14", {5'h0c, 3'd4, 8'hFF}, 16'h0, UOP_NOP, 5'd0, 5'd0, 5'd0, 32'd0, 2, 1'b1);
        chk("R14", {5'h0c, 3'd6, 8'h00}, 16'h0, UOP_NOP, 5'd0, 5'd0, 5'd0, 32'd0, 2, 1'b1);
    endtask

    // R2: an idle cycle clears valid and leaves the captured fields untouched.
    task automatic t_idle;
        chk("R2", {5'h0d, 3'd3, 8'h5A}, 16'h0, UOP_ADDI, 5'd3, 5'd0, 5'd0, 32'h5A, 2, 1'b0);
        @(negedge clk);
        i_valid = 1'b0;
        i_insn  = {5'h02, 11'h7FF};
        @(posedge clk);
        #1;
        checks++;
        if (o_valid !== 1'b0 || o_cls !== 6'(UOP_ADDI) || o_rd !== 5'd3 || o_imm !== 32'h5A) begin
            fails++;
            $display("FAIL R2 idle: act v=%0b cls=%0d rd=%0d imm=%h exp v=0 cls=%0d rd=3 imm=0000005a",
                     o_valid, o_cls, o_rd, o_imm, 6'(UOP_ADDI));
        end
    endtask

    initial begin
        t_reset();
        t_regmap();
        t_shifts();
        t_branches();
        t_mem();
        t_sp_pc();
        t_jal();
        t_imm_alu();
        t_rrr();
        t_rr();
        t_moves();
        t_reserved();
        t_idle();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: act=running exp=finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule